// File: doc/BRIEF.md
# Lockable Software Reset Bank

This block gives software a set of independent, active-low reset requests, one per entry, each aimed at a target clock domain. Every entry owns two one-bit registers on a simple strobe-based register bus. One is a lock bit that starts at 1 and that software may only clear. The other is the reset control bit, which software may change only while the lock bit is still 1.

Once firmware clears an entry's lock bit, that entry's control bit is frozen at whatever value it held. No later write can reopen the entry short of a block reset. Each control bit drives a reset output in the target domain. The output asserts at once and releases only after a two-stage synchronizer clocked by the target clock.

The register map places the N lock registers at word addresses 0 to N-1 and the N control registers at N to 2N-1. Each register holds its value in data bit 0. The other data bits read as zero.

Top module: `swrst_lock_bank`

## Requirements
- R1: After reset every lock bit and every control bit reads 1, and once the target reset has been released every reset output is 1.
- R2: Writing 0 (data bit 0) to a lock register at address i clears that lock bit. Writing 1 to it never sets it again.
- R3: When lock bits are cleared one after another, every bit cleared earlier stays cleared.
- R4: A write to the control register at address N+i stores data bit 0 when lock bit i is 1. This includes writing 1 to release a reset that software asserted.
- R5: A write to the control register of an entry whose lock bit is 0 leaves both its readback and its reset output unchanged.
- R6: Starting from all control bits at 1, writing 0 to every control register gives a readback of (inverted lock vector) OR (written value).
- R7: When a control bit becomes 0, its reset output goes to 0 without waiting for a target clock edge.
- R8: When a control bit returns to 1, its reset output is still 0 before two target clock edges have passed. It is 1 within 3 target clock cycles.
- R9: Read data appears on the cycle after the read strobe, with bits 31 to 1 equal to zero.
- R10: An access to an address of 2N or above returns read data 0 and raises err for exactly one cycle. It changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Asynchronous active-low reset of the register domain |
| tgt_clk | input | 1 | Target domain clock |
| tgt_rst_n | input | 1 | Asynchronous active-low reset of the target domain synchronizers |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Word address |
| wdata | input | DW | Write data, bit 0 meaningful |
| rdata | output | DW | Read data, valid the cycle after rd_en |
| err | output | 1 | One-cycle flag for an access outside the map |
| rst_req_n | output | N | Active-low reset outputs, one per entry, in the target domain |

## Verification
The assertions assume that wr_en and rd_en are never both high in the same cycle. They also assume that addr and wdata are steady while a strobe is high, and that tgt_rst_n is released no earlier than rst_n. The stimulus meets these assumptions. Each access is a single-cycle strobe driven on the falling edge of clk, and the two strobes are never raised together. Both resets are released together after several cycles.

The target clock runs at a period unrelated to the bus clock, so the release timing is checked over varying phase. Out-of-range accesses use addresses just past the map and at its top.

// File: rtl/swrst_lock_bank.sv
module swrst_lock_bank #(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tgt_clk,
  input  logic          tgt_rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic [N-1:0]  rst_req_n
);
  localparam int NREG = 2 * N;

  logic [N-1:0] en_q;
  logic [N-1:0] ctrl_q;
  logic         rd_bit;
  logic         unused_wdata;

  wire in_map = int'(addr) < NREG;

  assign unused_wdata = ^wdata[DW-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '1;
      ctrl_q <= '1;
    end else if (wr_en) begin
      for (int i = 0; i < N; i++) begin
        if (int'(addr) == i && !wdata[0]) en_q[i] <= 1'b0;
        if (int'(addr) == N + i && en_q[i]) ctrl_q[i] <= wdata[0];
      end
    end
  end

  always_comb begin
    rd_bit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (int'(addr) == i)     rd_bit = en_q[i];
      if (int'(addr) == N + i) rd_bit = ctrl_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      rdata <= (rd_en && in_map) ? {{(DW-1){1'b0}}, rd_bit} : '0;
      err   <= (wr_en || rd_en) && !in_map;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_sync
    logic [1:0] stg;
    wire        arst_n = ctrl_q[g] & tgt_rst_n;

    always_ff @(posedge tgt_clk or negedge arst_n) begin
      if (!arst_n) stg <= 2'b00;
      else         stg <= {stg[0], 1'b1};
    end
    assign rst_req_n[g] = stg[1];

    assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(en_q[g]));

    assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(addr) == N + g && !en_q[g]) |=> $stable(ctrl_q[g]));

    assert_async_assert_R7: assert property (@(posedge tgt_clk) disable iff (!tgt_rst_n)
      !ctrl_q[g] |-> !rst_req_n[g]);
  end

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rdata[DW-1:1] == '0));

  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && !in_map) |=> (err && rdata == '0));

  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |=> !err);

  assert_oob_nochange_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_map) |=> ($stable(en_q) && $stable(ctrl_q)));
endmodule

// File: tb/swrst_lock_bank_tb.sv
module swrst_lock_bank_tb;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          tgt_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tgt_rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          err;
  logic [N-1:0]  rst_req_n;

  int total = 0;
  int bad = 0;
  logic [N-1:0] m_en = '1;
  logic [N-1:0] m_ctrl = '1;

  always #2 clk = ~clk;
  always #3.5 tgt_clk = ~tgt_clk;

  swrst_lock_bank #(.N(N), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tgt_clk(tgt_clk), .tgt_rst_n(tgt_rst_n),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .err(err), .rst_req_n(rst_req_n)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [DW-1:0] d);
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < N) begin
      if (!d[0]) m_en[a] = 1'b0;
    end else if (a < 2 * N) begin
      if (m_en[a-N]) m_ctrl[a-N] = d[0];
    end
  endtask

  task automatic bus_rd(input int a, output logic [DW-1:0] d, output logic e);
    addr = AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata; e = err;
  endtask

  task automatic wait_tgt(input int n);
    repeat (n) @(posedge tgt_clk);
    @(negedge clk);
  endtask

  task automatic check_model(input string req);
    logic [DW-1:0] d;
    logic e;
    for (int i = 0; i < N; i++) begin
      bus_rd(i, d, e);
      chk(d == DW'(m_en[i]), {req, " lock readback"}, d, DW'(m_en[i]));
      bus_rd(N + i, d, e);
      chk(d == DW'(m_ctrl[i]), {req, " ctrl readback"}, d, DW'(m_ctrl[i]));
    end
  endtask

  task automatic t_reset;
    check_model("R1");
    wait_tgt(3);
    chk(rst_req_n == '1, "R1 outputs", DW'(rst_req_n), DW'({N{1'b1}}));
  endtask

  task automatic t_read_timing;
    logic [DW-1:0] d;
    logic e;
    addr = AW'(N); rd_en = 1'b1;
    chk(rdata == '0, "R9 no data before edge", rdata, '0);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata; e = err;
    chk(d == 32'h1, "R9 data next cycle, upper bits zero", d, 32'h1);
    chk(e == 1'b0, "R9 no err in map", DW'(e), '0);
  endtask

  task automatic t_ctrl_enabled;
    logic [DW-1:0] d;
    logic e;
    bus_wr(N + 0, 32'h0);
    chk(rst_req_n[0] == 1'b0, "R7 immediate assert", DW'(rst_req_n[0]), '0);
    bus_rd(N + 0, d, e);
    chk(d == 32'h0, "R4 ctrl cleared", d, '0);
    bus_wr(N + 0, 32'hFFFF_FFFF);
    chk(rst_req_n[0] == 1'b0, "R8 not released before sync", DW'(rst_req_n[0]), '0);
    wait_tgt(3);
    chk(rst_req_n[0] == 1'b1, "R8 released within 3 target cycles", DW'(rst_req_n[0]), 1);
    bus_rd(N + 0, d, e);
    chk(d == 32'h1, "R4 release by write of 1", d, 32'h1);
  endtask

  task automatic t_lock_write_one;
    logic [DW-1:0] d;
    logic e;
    bus_wr(1, 32'h1);
    bus_rd(1, d, e);
    chk(d == 32'h1, "R2 write 1 keeps lock bit", d, 32'h1);
    bus_wr(1, 32'h0);
    bus_rd(1, d, e);
    chk(d == 32'h0, "R2 write 0 clears", d, '0);
    bus_wr(1, 32'h1);
    bus_rd(1, d, e);
    chk(d == 32'h0, "R2 cleared bit not set again", d, '0);
  endtask

  task automatic t_locked_ctrl;
    logic [DW-1:0] d;
    logic e;
    bus_wr(N + 1, 32'h0);
    bus_rd(N + 1, d, e);
    chk(d == 32'h1, "R5 locked ctrl unchanged", d, 32'h1);
    wait_tgt(4);
    chk(rst_req_n[1] == 1'b1, "R5 locked output unchanged", DW'(rst_req_n[1]), 1);
  endtask

  task automatic t_out_of_range;
    logic [DW-1:0] d;
    logic e;
    bus_wr(2 * N, 32'h0);
    chk(err == 1'b1, "R10 err on write", DW'(err), 1);
    @(negedge clk);
    chk(err == 1'b0, "R10 err one cycle", DW'(err), '0);
    bus_rd(2 * N + 1, d, e);
    chk(d == '0 && e, "R10 read out of range", d, '0);
    bus_rd((1 << AW) - 1, d, e);
    chk(d == '0 && e, "R10 read top address", d, '0);
    @(negedge clk);
    chk(err == 1'b0, "R10 err cleared", DW'(err), '0);
    check_model("R10 no state change");
  endtask

  task automatic t_sequential_lock;
    logic [DW-1:0] d;
    logic e;
    logic [N-1:0] rb;
    for (int i = 0; i < N; i++) begin
      bus_wr(i, 32'h0);
      check_model("R3");
      for (int j = 0; j < N; j++) bus_wr(N + j, 32'h0);
      for (int j = 0; j < N; j++) begin
        bus_rd(N + j, d, e);
        rb[j] = d[0];
      end
      chk(rb == (~m_en | {N{1'b0}}), "R6 readback vs lock vector", DW'(rb), DW'(~m_en));
      chk(rst_req_n == rb, "R6 outputs follow ctrl", DW'(rst_req_n), DW'(rb));
      for (int j = 0; j < N; j++) bus_wr(N + j, 32'h1);
      wait_tgt(3);
      chk(rst_req_n == '1, "R8 all released", DW'(rst_req_n), DW'({N{1'b1}}));
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    tgt_rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_timing();
    t_ctrl_enabled();
    t_out_of_range();
    t_lock_write_one();
    t_locked_ctrl();
    t_sequential_lock();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule